// File: doc/BRIEF.md
# Labelled Half-Word Store Unit

This unit carries out the memory-side part of the store and load instructions of a small 16-bit coprocessor. The memory it drives holds 32-bit words. It receives instruction fields that are already decoded: opcode, sub-operation, the value of the data register, the value of the address register, an 11-bit word offset, a 2-bit tag, a half select, a write mode, a load half select and the current program counter. From these it drives a word-addressed memory port with a two-bit half-word write enable. A store can place a 16-bit value raw, place a 2-bit tag above 14 data bits, or fill a whole word with the program counter, the tag and the data.

Two store styles exist. A manual store names its own address and half. An auto store takes its address from an internal pointer. That pointer is loaded by a pointer-set operation, and half-word auto stores fill the low half and then the high half of a word before the pointer moves on. Loads return one half of the addressed word one cycle after the request.

Top module: `halfword_store_unit`

## Requirements
- R1: A manual store or a load addresses word (address register + offset) modulo 2^AW. Both values are counted in 32-bit words.
- R2: Write mode 0 writes the full word {PC[10:0], 3'b000, tag[1:0], data[15:0]} and sets both write enables (mem_we = 2'b11).
- R3: Write mode 1 writes the half-word {tag[1:0], data[13:0]} into the selected half. In any half-word store the half value appears on both halves of mem_wdata.
- R4: Write mode 3 writes data[15:0] unchanged into the selected half.
- R5: In a manual half-word store, upper_sel=0 writes bits 15:0 (mem_we = 2'b01) and upper_sel=1 writes bits 31:16 (mem_we = 2'b10).
- R6: Store opcode 6 with sub-operation 3 loads the pointer from the low AW bits of the offset and resets the phase to low. It asserts no write enable.
- R7: An auto store (opcode 6, sub-operation 1) in mode 1 or 3 writes at the pointer. It writes the low half first and the high half second, and the pointer advances by one (mod 2^AW) after the high half.
- R8: An auto store in mode 0 writes the full word at the pointer and advances the pointer by one. The phase is left unchanged.
- R9: Write mode 2 in a manual or auto store asserts no write enable and leaves the pointer and phase unchanged.
- R10: A load (opcode 13) asserts mem_re. In the next cycle ld_valid is 1, and ld_data is bits 15:0 of the word when ld_upper=1 or bits 31:16 when ld_upper=0.
- R11: After reset the pointer is 0, the phase is low, no write enable is set and ld_valid is 0.
- R12: With op_valid low, with any opcode other than 6 or 13, or with store sub-operations other than 1, 3 and 4, the unit asserts neither write enable nor mem_re.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Instruction fields are valid this cycle |
| op_code | input | 4 | Major opcode (6 store, 13 load) |
| sub_op | input | 3 | Store sub-operation (1 auto, 3 pointer set, 4 manual) |
| data_val | input | 16 | Value of the data register |
| addr_val | input | 16 | Value of the address register, in words |
| word_off | input | 11 | Word offset, or the pointer value for a pointer set |
| tag | input | 2 | Tag packed with stored data |
| upper_sel | input | 1 | Manual store half select |
| wr_mode | input | 2 | Write mode 0/1/2/3 |
| ld_upper | input | 1 | Load half select (1 low half, 0 high half) |
| pc | input | 11 | Program counter of the instruction |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_we | output | 2 | Half write enables (bit0 low, bit1 high) |
| mem_re | output | 1 | Memory read request |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Load result |

## Verification
The bench builds the unit with AW = 6, so the memory holds 64 words. With that width, address sums past the top of memory wrap and the auto pointer runs through every word, so wrap-around of both the manual address and the pointer pair sequence occurs in a short run. The pointer is observed through the addresses of auto stores. Random mixes of all write modes, sub-operations and invalid opcodes are interleaved with pointer resets.

// File: rtl/hws_pkg.sv
`timescale 1ns/1ps
package hws_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;
    localparam int PC_W   = 11;
    localparam int OFF_W  = 11;

    localparam logic [3:0] OPC_STORE  = 4'd6;
    localparam logic [3:0] OPC_LOAD   = 4'd13;
    localparam logic [2:0] SUB_AUTO   = 3'd1;
    localparam logic [2:0] SUB_PTRSET = 3'd3;
    localparam logic [2:0] SUB_MANUAL = 3'd4;

    localparam logic [1:0] WM_FULL   = 2'd0;
    localparam logic [1:0] WM_TAGGED = 2'd1;
    localparam logic [1:0] WM_NONE   = 2'd2;
    localparam logic [1:0] WM_RAW    = 2'd3;
endpackage

// File: rtl/hws_pack.sv
`timescale 1ns/1ps
module hws_pack
    import hws_pkg::*;
(
    input  logic [1:0]        wr_mode,
    input  logic [1:0]        tag,
    input  logic [HALF_W-1:0] data_val,
    input  logic [PC_W-1:0]   pc,
    output logic [HALF_W-1:0] half_val,
    output logic [WORD_W-1:0] full_val
);
    always_comb begin
        full_val = {pc, 3'b000, tag, data_val};
        if (wr_mode == WM_TAGGED) half_val = {tag, data_val[HALF_W-3:0]};
        else                      half_val = data_val;
    end
endmodule

// File: rtl/hws_autoptr.sv
`timescale 1ns/1ps
module hws_autoptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_val,
    input  logic          adv_half,
    input  logic          adv_full,
    output logic [AW-1:0] ptr_q,
    output logic          phase_q
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          phase;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_en) begin
            st_d.ptr   = set_val;
            st_d.phase = 1'b0;
        end else if (adv_full) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end else if (adv_half) begin
            if (st_q.phase) begin
                st_d.ptr   = st_q.ptr + 1'b1;
                st_d.phase = 1'b0;
            end else begin
                st_d.phase = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr_q   = st_q.ptr;
    assign phase_q = st_q.phase;

    // R7
    half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_half && phase_q && !set_en && !adv_full) |=> (ptr_q == AW'($past(ptr_q) + 1'b1)) && !phase_q);

    // R6
    ptr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (ptr_q == $past(set_val)) && !phase_q);
endmodule

// File: rtl/hws_ldret.sv
`timescale 1ns/1ps
module hws_ldret
    import hws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              re,
    input  logic              low_sel,
    input  logic [WORD_W-1:0] rdata,
    output logic              ld_valid,
    output logic [HALF_W-1:0] ld_data
);
    typedef struct packed {
        logic valid;
        logic sel;
    } ld_st_t;

    ld_st_t st_d, st_q;

    always_comb begin
        st_d.valid = re;
        st_d.sel   = re ? low_sel : st_q.sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ld_valid = st_q.valid;
    assign ld_data  = st_q.sel ? rdata[HALF_W-1:0] : rdata[WORD_W-1:HALF_W];

    // R10
    ld_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> ld_valid);

    // R10
    ld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> !ld_valid);
endmodule

// File: rtl/halfword_store_unit.sv
`timescale 1ns/1ps
module halfword_store_unit
    import hws_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [2:0]    sub_op,
    input  logic [15:0]   data_val,
    input  logic [15:0]   addr_val,
    input  logic [10:0]   word_off,
    input  logic [1:0]    tag,
    input  logic          upper_sel,
    input  logic [1:0]    wr_mode,
    input  logic          ld_upper,
    input  logic [10:0]   pc,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    output logic [1:0]    mem_we,
    output logic          mem_re,
    input  logic [31:0]   mem_rdata,
    output logic          ld_valid,
    output logic [15:0]   ld_data
);
    localparam int SUM_W = 16;

    logic          is_st, is_ld, do_manual, do_auto, do_set, wr_on, is_full;
    logic [AW-1:0] eff_addr, ptr_q;
    logic          phase_q, adv_half, adv_full;
    logic [15:0]   half_val;
    logic [31:0]   full_val;
    logic [SUM_W-1:0] addr_sum;

    hws_pack u_pack (
        .wr_mode  (wr_mode),
        .tag      (tag),
        .data_val (data_val),
        .pc       (pc),
        .half_val (half_val),
        .full_val (full_val)
    );

    hws_autoptr #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (do_set),
        .set_val  (AW'(word_off)),
        .adv_half (adv_half),
        .adv_full (adv_full),
        .ptr_q    (ptr_q),
        .phase_q  (phase_q)
    );

    hws_ldret u_ld (
        .clk      (clk),
        .rst_n    (rst_n),
        .re       (is_ld),
        .low_sel  (ld_upper),
        .rdata    (mem_rdata),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

    always_comb begin
        is_st     = op_valid && (op_code == OPC_STORE);
        is_ld     = op_valid && (op_code == OPC_LOAD);
        do_manual = is_st && (sub_op == SUB_MANUAL);
        do_auto   = is_st && (sub_op == SUB_AUTO);
        do_set    = is_st && (sub_op == SUB_PTRSET);
        wr_on     = (wr_mode != WM_NONE);
        is_full   = (wr_mode == WM_FULL);
        addr_sum  = addr_val + SUM_W'(word_off);
        eff_addr  = AW'(addr_sum);
        adv_full  = do_auto && is_full;
        adv_half  = do_auto && wr_on && !is_full;

        mem_re    = is_ld;
        mem_addr  = do_auto ? ptr_q : eff_addr;
        mem_wdata = is_full ? full_val : {half_val, half_val};
        mem_we    = 2'b00;
        if ((do_manual || do_auto) && wr_on) begin
            if (is_full)        mem_we = 2'b11;
            else if (do_manual) mem_we = upper_sel ? 2'b10 : 2'b01;
            else                mem_we = phase_q ? 2'b10 : 2'b01;
        end
    end

    // R2
    full_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd6 && (sub_op == 3'd4 || sub_op == 3'd1) && wr_mode == 2'd0) |-> mem_we == 2'b11);

    // R9
    noop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == 2'd2) |-> mem_we == 2'b00);

    // R12
    we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we != 2'b00) |-> !mem_re);

    // R5
    half_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode == 2'd1 || wr_mode == 2'd3) |-> $countones(mem_we) <= 1);
endmodule

// File: tb/test_halfword_store_unit.sv
`timescale 1ns/1ps
module test_halfword_store_unit;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic op_valid = 0, upper_sel = 0, ld_upper = 0;
    logic [3:0] op_code = 0;
    logic [2:0] sub_op = 0;
    logic [15:0] data_val = 0, addr_val = 0;
    logic [10:0] word_off = 0, pc = 0;
    logic [1:0] tag = 0, wr_mode = 0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = 0;
    logic [1:0] mem_we;
    logic mem_re, ld_valid;
    logic [15:0] ld_data;

    int checks = 0, fails = 0;
    logic [31:0] mem [DEPTH];
    logic [31:0] ref_mem [DEPTH];
    int rptr = 0;
    bit rphase = 0;

    always #2.5 clk = ~clk;

    halfword_store_unit #(.AW(AW)) i_halfword_store_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .sub_op(sub_op),
        .data_val(data_val), .addr_val(addr_val), .word_off(word_off), .tag(tag),
        .upper_sel(upper_sel), .wr_mode(wr_mode), .ld_upper(ld_upper), .pc(pc),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .ld_valid(ld_valid), .ld_data(ld_data)
    );

    always @(posedge clk) begin
        if (mem_we[0]) mem[mem_addr][15:0]  <= mem_wdata[15:0];
        if (mem_we[1]) mem[mem_addr][31:16] <= mem_wdata[31:16];
        if (mem_re)    mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_half(input logic [1:0] wm, input logic [1:0] lb, input logic [15:0] d);
        return (wm == 2'd1) ? {lb, d[13:0]} : d;
    endfunction

    task automatic do_op(input bit v, input logic [3:0] oc, input logic [2:0] so, input logic [15:0] dv,
                         input logic [15:0] av, input logic [10:0] off, input logic [1:0] lb,
                         input bit up, input logic [1:0] wm, input bit ru, input logic [10:0] p);
        bit st, ld, man, aut, pset;
        logic [1:0] ewe;
        int ea, addr;
        logic [31:0] ew;
        logic [15:0] eld, h;
        string t;
        @(negedge clk);
        op_valid = v; op_code = oc; sub_op = so; data_val = dv; addr_val = av; word_off = off;
        tag = lb; upper_sel = up; wr_mode = wm; ld_upper = ru; pc = p;
        #1;
        st = v && oc == 4'd6; ld = v && oc == 4'd13;
        man = st && so == 3'd4; aut = st && so == 3'd1; pset = st && so == 3'd3;
        ea = (int'(av) + int'(off)) % DEPTH;
        addr = aut ? rptr : ea;
        h = exp_half(wm, lb, dv);
        ew = (wm == 2'd0) ? {p, 3'b000, lb, dv} : {h, h};
        ewe = 2'b00;
        if ((man || aut) && wm != 2'd2) begin
            if (wm == 2'd0) ewe = 2'b11;
            else if (man)   ewe = up ? 2'b10 : 2'b01;
            else            ewe = rphase ? 2'b10 : 2'b01;
        end
        if (!(man || aut || pset || ld)) t = "R12";
        else if (ld) t = "R10";
        else if (pset) t = "R6";
        else if (wm == 2'd2) t = "R9";
        else if (aut) t = (wm == 2'd0) ? "R8" : "R7";
        else if (wm == 2'd0) t = "R2";
        else if (wm == 2'd1) t = "R3/R5";
        else t = "R4/R5";
        chk(mem_we == ewe, {t, " we"}, 32'(mem_we), 32'(ewe));
        chk(mem_re == ld, {t, " re"}, 32'(mem_re), 32'(ld));
        if (ewe != 0 || ld)
            chk(int'(mem_addr) == addr, aut ? {t, " addr"} : "R1 addr", 32'(mem_addr), 32'(addr));
        if (ewe[0]) chk(mem_wdata[15:0] == ew[15:0], {t, " wdata lo"}, mem_wdata, ew);
        if (ewe[1]) chk(mem_wdata[31:16] == ew[31:16], {t, " wdata hi"}, mem_wdata, ew);
        eld = ru ? ref_mem[ea][15:0] : ref_mem[ea][31:16];
        if (ewe[0]) ref_mem[addr][15:0]  = ew[15:0];
        if (ewe[1]) ref_mem[addr][31:16] = ew[31:16];
        if (pset) begin rptr = int'(off) % DEPTH; rphase = 0; end
        else if (aut && wm == 2'd0) rptr = (rptr + 1) % DEPTH;
        else if (aut && wm != 2'd2) begin
            if (rphase) begin rptr = (rptr + 1) % DEPTH; rphase = 0; end
            else rphase = 1;
        end
        @(posedge clk); #1;
        chk(ld_valid == ld, "R10 valid", 32'(ld_valid), 32'(ld));
        if (ld) chk(ld_data == eld, "R10 data", 32'(ld_data), 32'(eld));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = 32'hA5A5_0000 ^ (i * 32'h0001_0203);
            ref_mem[i] = mem[i];
        end
        #12; rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(mem_we == 2'b00, "R11 we", 32'(mem_we), 0);
        chk(ld_valid == 1'b0, "R11 ld_valid", 32'(ld_valid), 0);
        // R11: first auto store hits word 0 low half
        do_op(1, 6, 1, 16'h1234, 0, 0, 0, 0, 3, 0, 0);
        do_op(1, 6, 1, 16'h5678, 0, 0, 0, 0, 3, 0, 0);
        // R6 / R7 pointer pairs with wrap
        do_op(1, 6, 3, 0, 0, 11'd62, 0, 0, 0, 0, 0);
        do_op(1, 6, 1, 16'hFFFF, 0, 0, 2'd2, 0, 1, 0, 0);
        do_op(1, 6, 2, 16'h1111, 0, 0, 2'd1, 0, 2, 0, 0);
        do_op(1, 6, 1, 16'h2222, 0, 0, 2'd3, 0, 1, 0, 0);
        do_op(1, 6, 1, 16'h3333, 0, 0, 2'd2, 0, 1, 0, 0);
        do_op(1, 6, 1, 16'h4444, 0, 0, 2'd1, 0, 3, 0, 0);
        do_op(1, 6, 1, 16'h5555, 0, 0, 2'd0, 0, 1, 0, 0);
        do_op(1, 6, 1, 16'h6666, 0, 0, 2'd3, 0, 3, 0, 0);
        do_op(1, 6, 1, 16'h7777, 0, 0, 2'd1, 0, 0, 0, 11'h7FF);
        do_op(1, 6, 1, 16'h8888, 0, 0, 2'd3, 0, 3, 0, 0);
        // R1 wrap and R2 full word, R10 loads
        do_op(1, 6, 4, 16'hBEEF, 16'd60, 11'd10, 2'd3, 0, 0, 0, 11'h5A5);
        do_op(1, 13, 0, 0, 16'd60, 11'd10, 0, 0, 0, 1, 0);
        do_op(1, 13, 0, 0, 16'd60, 11'd10, 0, 0, 0, 0, 0);
        do_op(0, 6, 4, 16'hDEAD, 0, 1, 0, 0, 0, 0, 0);
        do_op(1, 13, 0, 0, 0, 1, 0, 0, 0, 1, 0);
        for (int n = 0; n < 600; n++) begin
            int k;
            logic [3:0] oc;
            logic [2:0] so;
            k = int'($urandom % 10);
            oc = (k < 6) ? 4'd6 : (k < 9) ? 4'd13 : 4'($urandom);
            case ($urandom % 8)
                0:       so = 3'd3;
                1, 2, 3: so = 3'd1;
                4, 5, 6: so = 3'd4;
                default: so = 3'($urandom);
            endcase
            do_op(($urandom % 16) != 0, oc, so, 16'($urandom), 16'($urandom), 11'($urandom),
                  2'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 11'($urandom));
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule